// File: doc/BRIEF.md
# CAN Transmit Mailbox Bank

This block holds outgoing CAN messages in three transmit mailboxes that software fills through a small register port. Each mailbox has a header word (identifier, extended-format flag, frame kind and transmit request), two payload words and a length word. Software loads the payload and length first. It then writes the header with the request bit set. That write locks the mailbox until the frame has gone out.

Locked mailboxes that have not yet been handed on are offered to a downstream bit-level transmitter over a valid/ready handshake, lowest index first. The transmitter accepts a mailbox and later reports completion by index. The bank then drops the request and the mailbox becomes empty and writable again. A status word shows one empty flag per mailbox.

Top module: `can_txmb_bank`

## Requirements
- R1: After reset the status word (byte address 0x30, bits [2:0] = empty flag of mailbox 2..0) reads 3'b111 and `tx_valid` is 0.
- R2: Mailbox k occupies byte addresses k*0x10 to k*0x10+0xC. The header is at +0x0, payload bytes 0..3 at +0x4, payload bytes 4..7 at +0x8 and the length at +0xC (bits [3:0]). Reads return data one cycle after `reg_rd`.
- R3: In the header word, bit 0 is the transmit request, bit 1 is the frame kind (0 data, 1 remote), bit 2 is the extended-identifier flag and bits [31:3] are the 29-bit identifier.
- R4: A header write with bit 0 set to a mailbox whose empty flag is 1 stores the word and clears that empty flag.
- R5: Any write to a mailbox whose empty flag is 0 is discarded, and its stored contents read back unchanged.
- R6: When several mailboxes are pending and `tx_valid` is low, the lowest-index pending mailbox is offered first.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_idx` and every frame field stay unchanged.
- R8: The cycle after a handshake (`tx_valid` and `tx_ready` both high), `tx_valid` is low. An accepted mailbox is never offered again before its completion.
- R9: A completion (`done_valid` with `done_idx`) for an accepted mailbox clears its request bit (header bit 0 reads 0) and sets its empty flag.
- R10: A completion for a mailbox with no request, or for one whose request has not yet been accepted by the transmitter, is ignored.
- R11: The offered mailbox's identifier, extended flag, frame kind, length and payload appear on the `tx_*` outputs in the same cycle as `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| tx_valid | output | 1 | A mailbox is offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the offered mailbox |
| tx_idx | output | 2 | Index of the offered mailbox |
| tx_id | output | 29 | Identifier of the offered frame |
| tx_ext | output | 1 | Extended identifier flag |
| tx_remote | output | 1 | 1 for a remote frame, 0 for a data frame |
| tx_dlc | output | 4 | Data length code |
| tx_data | output | 64 | Payload, byte 0 in bits [7:0] |
| done_valid | input | 1 | Transmitter reports a finished frame |
| done_idx | input | 2 | Mailbox index of the finished frame |

## Verification
The bench writes a payload word into a locked mailbox and reads it back. A design without write gating would return the new value. It raises a completion for an empty mailbox and for one that is offered but not yet accepted. A design that clears on any completion would free the wrong slot or withdraw a live offer. It loads a high-index mailbox and then a lower one while `tx_ready` is held low. A design with a wrong priority order, or one that re-arbitrates during a stall, would switch `tx_idx` mid-offer or serve the higher index second. It also watches the cycles after each handshake, where a design that fails to mask the accepted slot would offer the same mailbox twice.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int ID_W   = 29;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;

  // header bits above the request bit: {id, ext, remote}
  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            ext;
    logic            remote;
  } txmb_hdr_t;

  typedef enum logic [1:0] {
    W_HDR = 2'd0,
    W_DLO = 2'd1,
    W_DHI = 2'd2,
    W_DLC = 2'd3
  } txmb_word_e;
endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
  import can_txmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  txmb_word_e        wr_word,
  input  logic [31:0]       wdata,
  input  logic              take,
  input  logic              done,
  output logic              empty,
  output logic              pending,
  output logic              req,
  output txmb_hdr_t         hdr,
  output logic [DATA_W-1:0] data,
  output logic [DLC_W-1:0]  dlc
);
  logic      req_q, sent_q;
  txmb_hdr_t hdr_q;
  logic [31:0] dlo_q, dhi_q;
  logic [DLC_W-1:0] dlc_q;

  logic wr_ok;
  assign wr_ok = wr_en && !req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      sent_q <= 1'b0;
    end else if (done && req_q && sent_q) begin
      req_q  <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      if (take) sent_q <= 1'b1;
      if (wr_ok && wr_word == W_HDR) req_q <= wdata[0];
    end
  end

  // contents carry no reset: undefined until written
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      case (wr_word)
        W_HDR: hdr_q <= txmb_hdr_t'(wdata[31:1]);
        W_DLO: dlo_q <= wdata;
        W_DHI: dhi_q <= wdata;
        W_DLC: dlc_q <= wdata[DLC_W-1:0];
        default: ;
      endcase
    end
  end

  assign empty   = !req_q;
  assign pending = req_q && !sent_q;
  assign req     = req_q;
  assign hdr     = hdr_q;
  assign data    = {dhi_q, dlo_q};
  assign dlc     = dlc_q;

  // R5
  locked_stable_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |=> ($stable(dlo_q) && $stable(dhi_q) && $stable(dlc_q) && $stable(hdr_q)));
  // R9
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (done && req_q && sent_q) |=> !req_q);
  // R10
  done_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (done && req_q && !sent_q) |=> req_q);
endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb #(
  parameter int NUM_MB = 3,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_MB-1:0] pending,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [IDX_W-1:0]  tx_idx,
  output logic [NUM_MB-1:0] take
);
  logic [IDX_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (pending[i]) pick = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_idx   <= '0;
    end else if (tx_valid) begin
      if (tx_ready) tx_valid <= 1'b0;
    end else if (|pending) begin
      tx_valid <= 1'b1;
      tx_idx   <= pick;
    end
  end

  always_comb begin
    take = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      take[i] = tx_valid && tx_ready && (tx_idx == IDX_W'(i));
    end
  end

  // R7
  offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_idx)));
  // R8
  handshake_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_valid);
  // R8
  take_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take));
endmodule

// File: rtl/can_txmb_bank.sv
module can_txmb_bank
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int SEL_W  = $clog2(NUM_MB + 1),
  localparam int ADDR_W = SEL_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [IDX_W-1:0]  tx_idx,
  output logic [ID_W-1:0]   tx_id,
  output logic              tx_ext,
  output logic              tx_remote,
  output logic [DLC_W-1:0]  tx_dlc,
  output logic [DATA_W-1:0] tx_data,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx
);
  logic [SEL_W-1:0] sel;
  txmb_word_e       word;
  assign sel  = reg_addr[ADDR_W-1:4];
  assign word = txmb_word_e'(reg_addr[3:2]);

  logic [NUM_MB-1:0] empty, pending, req, take;
  txmb_hdr_t         hdr_a  [NUM_MB];
  logic [DATA_W-1:0] data_a [NUM_MB];
  logic [DLC_W-1:0]  dlc_a  [NUM_MB];

  for (genvar k = 0; k < NUM_MB; k++) begin : g_mb
    can_txmb_slot u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (reg_wr && sel == SEL_W'(k)),
      .wr_word (word),
      .wdata   (reg_wdata),
      .take    (take[k]),
      .done    (done_valid && done_idx == IDX_W'(k)),
      .empty   (empty[k]),
      .pending (pending[k]),
      .req     (req[k]),
      .hdr     (hdr_a[k]),
      .data    (data_a[k]),
      .dlc     (dlc_a[k])
    );
  end

  can_txmb_arb #(.NUM_MB(NUM_MB)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .pending  (pending),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_idx   (tx_idx),
    .take     (take)
  );

  assign tx_id     = hdr_a[tx_idx].id;
  assign tx_ext    = hdr_a[tx_idx].ext;
  assign tx_remote = hdr_a[tx_idx].remote;
  assign tx_dlc    = dlc_a[tx_idx];
  assign tx_data   = data_a[tx_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      if (sel == SEL_W'(NUM_MB)) begin
        reg_rdata[NUM_MB-1:0] <= empty;
      end else begin
        for (int k = 0; k < NUM_MB; k++) begin
          if (sel == SEL_W'(k)) begin
            case (word)
              W_HDR: reg_rdata <= {hdr_a[k], req[k]};
              W_DLO: reg_rdata <= data_a[k][31:0];
              W_DHI: reg_rdata <= data_a[k][63:32];
              W_DLC: reg_rdata <= {{(32-DLC_W){1'b0}}, dlc_a[k]};
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R11
  offer_locked_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !empty[tx_idx]);
  // R7
  offer_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> ($stable(tx_id) && $stable(tx_data) && $stable(tx_remote)));
endmodule

// File: tb/can_txmb_bank_test.sv
module can_txmb_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [1:0]  tx_idx;
  logic [28:0] tx_id;
  logic        tx_ext, tx_remote;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        done_valid = 1'b0;
  logic [1:0]  done_idx = '0;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  can_txmb_bank uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic done(logic [1:0] i);
    @(negedge clk); done_valid = 1'b1; done_idx = i;
    @(negedge clk); done_valid = 1'b0;
  endtask

  task automatic hs;
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic wait_valid;
    for (int i = 0; i < 4 && !tx_valid; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] hdr(logic [28:0] id, logic ext, logic rmt, logic rq);
    return {id, ext, rmt, rq};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    check("R1 tx_valid", tx_valid, 0);
    rd(6'h30, d);
    check("R1 status", d, 32'h7);
  endtask

  task automatic t_single;
    logic [31:0] d;
    wr(6'h14, 32'h4433_2211);
    wr(6'h18, 32'h8877_6655);
    wr(6'h1C, 32'h8);
    wr(6'h10, hdr(29'h1ABC_DEF0, 1'b1, 1'b1, 1'b1));
    rd(6'h30, d);
    check("R4 status", d, 32'h5);
    wait_valid;
    check("R11 valid", tx_valid, 1);
    check("R11 idx", tx_idx, 1);
    check("R11 id", tx_id, 29'h1ABC_DEF0);
    check("R3 remote", tx_remote, 1);
    check("R3 ext", tx_ext, 1);
    check("R11 dlc", tx_dlc, 8);
    check("R11 data", tx_data, 64'h8877_6655_4433_2211);
    rd(6'h10, d);
    check("R2 header read", d, hdr(29'h1ABC_DEF0, 1'b1, 1'b1, 1'b1));
    wr(6'h14, 32'hDEAD_BEEF);
    rd(6'h14, d);
    check("R5 locked word", d, 32'h4433_2211);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R7 still valid", tx_valid, 1);
    check("R7 data held", tx_data, 64'h8877_6655_4433_2211);
    done(2'd1);
    check("R10 early done", tx_valid, 1);
    rd(6'h30, d);
    check("R10 status", d, 32'h5);
    hs;
    check("R8 gap", tx_valid, 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R8 no reoffer", tx_valid, 0);
    done(2'd0);
    rd(6'h30, d);
    check("R10 empty done", d, 32'h5);
    done(2'd1);
    rd(6'h30, d);
    check("R9 status", d, 32'h7);
    rd(6'h10, d);
    check("R9 req bit", d[0], 0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    wr(6'h2C, 32'h2);
    wr(6'h20, hdr(29'h222, 1'b0, 1'b0, 1'b1));
    wait_valid;
    check("R6 first idx", tx_idx, 2);
    wr(6'h0C, 32'h1);
    wr(6'h00, hdr(29'h111, 1'b0, 1'b0, 1'b1));
    @(negedge clk);
    check("R7 idx held", tx_idx, 2);
    check("R3 data kind", tx_remote, 0);
    wr(6'h10, hdr(29'h155, 1'b0, 1'b1, 1'b1));
    rd(6'h30, d);
    check("R4 all full", d, 32'h0);
    hs;
    wait_valid;
    check("R6 lowest next", tx_idx, 0);
    check("R6 id", tx_id, 29'h111);
    hs;
    wait_valid;
    check("R6 then mb1", tx_idx, 1);
    check("R6 mb1 id", tx_id, 29'h155);
    hs;
    done(2'd2); done(2'd0); done(2'd1);
    rd(6'h30, d);
    check("R9 all empty", d, 32'h7);
    rd(6'h2C, d);
    check("R2 dlc read", d, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_single;
    t_priority;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule